// File: doc/BRIEF.md
# Four-Lane Word Serializer

This block converts a 20-bit line-coded word, such as the output of a 16-bit-to-20-bit DC-balancing encoder, into a single serial bitstream running at the bit clock. Each word is split into four 5-bit groups. Each group goes to its own 5:1 flip-flop shift lane. The four lane heads are then merged by two levels of 2:1 multiplexers into one output bit.

Everything runs on a single bit-rate clock. The lanes shift on a quarter-rate enable. The first mux level switches at half rate and the second at full rate, and both are driven from a small phase counter. A new word is taken on a one-cycle word strobe. At the normal word rate the strobe comes once every 20 bit clocks, and the output then forms a continuous stream.

For eye and bit-error-rate measurement, a built-in 7-bit pseudo-random generator can take the place of the input word at each strobe.

Top module: `ser4_top`

## Requirements
- R1: After reset, and until the first word strobe has been taken, ser_o and ser_vld_o are both 0.
- R2: If word_stb_i is sampled high at clock edge E, coded bit k (k = 0..19) of the selected word is on ser_o, with ser_vld_o high, after edge E+1+k.
- R3: Bits leave in ascending index order: bit 0 first and bit 19 last. Lane i carries word bits i, i+4, i+8, i+12 and i+16, and the mux tree visits the lanes in the order 0, 1, 2, 3.
- R4: Strobes spaced exactly 20 cycles apart give a gap-free stream: bit 19 of one word is followed directly by bit 0 of the next.
- R5: When 20 bits have been sent and no new strobe was taken, ser_vld_o drops and ser_o is held at 0 until the next word starts.
- R6: A strobe that arrives before the current word is complete discards that word's unsent bits. The bit already in flight at the strobe edge is still delivered, and the new word's bit 0 follows.
- R7: With prbs_sel_i high at a strobe, the word comes from a 7-bit generator for the polynomial x^7+x^6+1. The generator starts at all ones after reset. Each step computes new = s[6]^s[5] and sets s = {s[5:0], new}. Word bit k is the k-th new bit, and the generator advances 20 steps per PRBS strobe and at no other time.
- R8: word_i is ignored when a PRBS word is taken, and word_i and prbs_sel_i have no effect on the output except in the cycle the strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 20 | Coded word, bit 0 sent first |
| word_stb_i | input | 1 | Word strobe, one cycle per word |
| prbs_sel_i | input | 1 | Take the PRBS word instead of word_i at this strobe |
| ser_o | output | 1 | Serial data |
| ser_vld_o | output | 1 | High while ser_o carries a word bit |

## Verification
The bench keeps a queue of expected bits. On each strobe it cuts the queue back to the one bit already in flight, so a design that did not discard unsent bits on an early strobe, or that dropped the in-flight bit, shows up as a misaligned stream. Single-bit walking words expose a wrong lane assignment or a swapped select bit in the mux tree, because the lone 1 then appears at the wrong position. Back-to-back strobes catch an off-by-one in the wrap of the phase counter, which would insert a dead cycle or skip a bit. A long run of PRBS words, with word_i and prbs_sel_i changed at random between strobes, catches a generator that steps at the wrong time or a design that samples its inputs outside the strobe cycle.

// File: rtl/ser4_pkg.sv
package ser4_pkg;
  localparam int PRBS_W = 7;

  // x^7 + x^6 + 1, new bit enters at the LSB
  function automatic logic [PRBS_W-1:0] prbs_step(input logic [PRBS_W-1:0] s);
    return {s[PRBS_W-2:0], s[6] ^ s[5]};
  endfunction
endpackage

// File: rtl/ser4_prbs.sv
module ser4_prbs
  import ser4_pkg::*;
#(
  parameter int WORD_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [WORD_W-1:0] word_o
);
  logic [PRBS_W-1:0] state_q, state_n;

  always_comb begin
    logic [PRBS_W-1:0] s;
    s = state_q;
    for (int k = 0; k < WORD_W; k++) begin
      word_o[k] = s[6] ^ s[5];
      s = prbs_step(s);
    end
    state_n = s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= '1;
    else if (adv_i) state_q <= state_n;
  end

  AST_PRBS_NO_LOCKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0); // R7
endmodule

// File: rtl/ser4_timing.sv
module ser4_timing #(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 5,
  localparam int SEL_W    = $clog2(NUM_LANES),
  localparam int SLOT_W   = $clog2(LANE_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  output logic             active_o,
  output logic             load_o,
  output logic             shift_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam logic [SEL_W-1:0]  SUB_LAST  = SEL_W'(NUM_LANES - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(LANE_W - 1);

  logic [SEL_W-1:0]  sub_q;
  logic [SLOT_W-1:0] slot_q;
  logic              active_q;
  logic              grp_end, word_end;

  assign grp_end  = (sub_q == SUB_LAST);
  assign word_end = grp_end && (slot_q == SLOT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q    <= '0;
      slot_q   <= '0;
      active_q <= 1'b0;
    end else if (stb_i) begin
      sub_q    <= '0;
      slot_q   <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      sub_q <= sub_q + 1'b1;
      if (grp_end) slot_q <= slot_q + 1'b1;
      if (word_end) begin
        active_q <= 1'b0;
        slot_q   <= '0;
      end
    end
  end

  assign active_o = active_q;
  assign load_o   = stb_i;
  assign shift_o  = active_q && grp_end && !stb_i;  // quarter-rate lane enable
  assign sel_o    = sub_q;                          // bit0 full rate, bit1 half rate

  AST_SLOT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= SLOT_LAST); // R5
endmodule

// File: rtl/ser4_lane.sv
module ser4_lane #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] par_i,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= par_i;
    else if (shift_i) sh_q <= {1'b0, sh_q[W-1:1]};
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/ser4_mux_tree.sv
module ser4_mux_tree #(
  parameter int N      = 4,
  localparam int SEL_W = $clog2(N)
) (
  input  logic [N-1:0]     lane_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             bit_o
);
  logic [N-1:0] cur;

  // level l: 2:1 muxes pick between j and j+half on the l-th select bit from the top
  always_comb begin
    cur = lane_i;
    for (int l = 0; l < SEL_W; l++) begin
      for (int j = 0; j < (N >> (l + 1)); j++) begin
        cur[j] = sel_i[SEL_W-1-l] ? cur[j + (N >> (l + 1))] : cur[j];
      end
    end
    bit_o = cur[0];
  end
endmodule

// File: rtl/ser4_top.sv
module ser4_top #(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 5,
  localparam int WORD_W   = NUM_LANES * LANE_W,
  localparam int SEL_W    = $clog2(NUM_LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_stb_i,
  input  logic              prbs_sel_i,
  output logic              ser_o,
  output logic              ser_vld_o
);
  logic [WORD_W-1:0]                 prbs_word, sel_word;
  logic [NUM_LANES-1:0][LANE_W-1:0]  lane_par;
  logic [NUM_LANES-1:0]              lane_bit;
  logic [SEL_W-1:0]                  sel;
  logic                              active, load, shift, tree_bit;

  ser4_prbs #(.WORD_W(WORD_W)) u_prbs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (word_stb_i && prbs_sel_i),
    .word_o (prbs_word)
  );

  assign sel_word = prbs_sel_i ? prbs_word : word_i;

  // lane i takes bits i, i+N, i+2N ...
  always_comb begin
    for (int i = 0; i < NUM_LANES; i++)
      for (int j = 0; j < LANE_W; j++)
        lane_par[i][j] = sel_word[j*NUM_LANES + i];
  end

  ser4_timing #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_timing (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (word_stb_i),
    .active_o (active),
    .load_o   (load),
    .shift_o  (shift),
    .sel_o    (sel)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    ser4_lane #(.W(LANE_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .shift_i (shift),
      .par_i   (lane_par[g]),
      .bit_o   (lane_bit[g])
    );
  end

  ser4_mux_tree #(.N(NUM_LANES)) u_tree (
    .lane_i (lane_bit),
    .sel_i  (sel),
    .bit_o  (tree_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_o     <= 1'b0;
      ser_vld_o <= 1'b0;
    end else begin
      ser_o     <= active & tree_bit;
      ser_vld_o <= active;
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_vld_o |-> !ser_o); // R5
  AST_VALID_AFTER_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_stb_i |=> ##1 ser_vld_o); // R2
  AST_VALID_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_vld_o) |-> $past(word_stb_i, 2)); // R1
  AST_FIRST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_stb_i && !prbs_sel_i) |=> ##1 (ser_o == $past(word_i[0], 2))); // R3
endmodule

// File: tb/ser4_top_test.sv
module ser4_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] word = '0;
  logic        stb = 1'b0;
  logic        psel = 1'b0;
  logic        ser, vld;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  mon_en   = 1'b0;
  bit  seen_stb = 1'b0;
  bit  done     = 1'b0;
  logic [1:0] exp_q[$];
  int         req_q[$];
  logic [6:0] ms = 7'h7F;

  always #5 clk = ~clk;

  ser4_top uut (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .word_stb_i(stb),
    .prbs_sel_i(psel), .ser_o(ser), .ser_vld_o(vld)
  );

  function automatic string req_name(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  default: return "R8";
    endcase
  endfunction

  function automatic logic [19:0] model_prbs();
    logic [19:0] w;
    for (int k = 0; k < 20; k++) begin
      w[k] = ms[6] ^ ms[5];
      ms   = {ms[5:0], w[k]};
    end
    return w;
  endfunction

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input int r);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: {vld,ser} actual %b expected %b at %0t", req_name(r), act, exp, $time);
    end
  endtask

  task automatic push(input logic v, input logic b, input int r);
    exp_q.push_back({v, b});
    req_q.push_back(r);
  endtask

  // caller sits just after a falling edge; returns the same way 'cycles' later
  task automatic send(input logic [19:0] w, input bit use_prbs, input int cycles, input int r);
    logic [19:0] eff;
    if (exp_q.size() == 0) push(1'b0, 1'b0, seen_stb ? 5 : 1);
    else while (exp_q.size() > 1) begin void'(exp_q.pop_back()); void'(req_q.pop_back()); end
    if (use_prbs) begin
      eff  = model_prbs();
      word = 20'($urandom);  // R8: ignored in PRBS mode
    end else begin
      eff  = w;
      word = w;
    end
    for (int k = 0; k < 20; k++) push(1'b1, eff[k], r);
    psel = use_prbs;
    stb  = 1'b1;
    seen_stb = 1'b1;
    @(negedge clk); #1;
    stb = 1'b0;
    word = 20'($urandom);
    psel = 1'($urandom);
    for (int c = 0; c < cycles - 1; c++) begin
      @(negedge clk); #1;
      word = 20'($urandom);  // R8: no effect between strobes
      psel = 1'($urandom);
    end
  endtask

  // monitor: pop one expected item per cycle, idle when queue is empty
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en) begin
        if (exp_q.size() != 0) check({vld, ser}, exp_q.pop_front(), req_q.pop_front());
        else check({vld, ser}, 2'b00, seen_stb ? 5 : 1);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // R1: outputs low in reset
    repeat (3) @(negedge clk);
    check({vld, ser}, 2'b00, 1);
    rst_n = 1'b1;
    #1;
    mon_en = 1'b1;
    repeat (5) @(negedge clk);  // R1: idle before first strobe
    #1;
    send(20'hA5C3B, 1'b0, 30, 2);   // R2 single word then idle (R5)
    send(20'h00001, 1'b0, 25, 3);   // R3 walking one, first position
    send(20'h80000, 1'b0, 25, 3);   // R3 last position
    send(20'h00010, 1'b0, 25, 3);   // R3 lane 0 second slot
    send(20'h12345, 1'b0, 20, 4);   // R4 back to back
    send(20'hFEDCB, 1'b0, 20, 4);
    send(20'h0F0F0, 1'b0, 30, 4);
    send(20'hFFFFF, 1'b0, 7, 6);    // R6 early strobe
    send(20'h00000, 1'b0, 11, 6);
    send(20'hABCDE, 1'b0, 30, 6);
    for (int i = 0; i < 14; i++) send(20'h0, 1'b1, 20, 7);  // R7 continuous PRBS
    send(20'h0, 1'b1, 30, 8);       // R8 PRBS with random word_i
    send(20'h5A5A5, 1'b0, 30, 8);   // R8 data mode after PRBS
    repeat (3) @(negedge clk);
    mon_en = 1'b0;
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fails++;
      $display("FAIL R5: queue actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule